// File: doc/BRIEF.md
# Host Interrupt Controller with Set/Clear Views

This block gathers up to 32 interrupt events raised inside the device and turns them into one interrupt line for a host processor. Each source raises a single-cycle pulse, which sets a sticky pending bit in a status word. A mask word decides which pending bits may reach the host. The host can load the mask as a whole word. It can also set or clear mask bits one at a time through two separate write addresses, so that no read-modify-write is needed.

The host has two ways to read the status. A peek view returns the pending bits and leaves them unchanged. A take view returns them and then clears every bit. The host can also clear chosen bits with a write-one acknowledge. The host line is registered so that it does not glitch. A configuration word gates the line on or off and selects its polarity.

The default source assignment is as follows:
- bit 0: receive buffer 0
- bit 1: transmit data
- bit 2: transmit transfer
- bit 3: receive buffer 1
- bit 4: receive transfer
- bits 5 and 6: event mailbox
- bit 7: wake
- bits 8 and 9: trace
- bit 10: command complete
- bit 14: initialisation complete

The bus is a simple synchronous one. A read returns its data on `bus_rdata` in the cycle after the request.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0x0000_0001 (only source 0 blocked), the status reads 0, the configuration reads 0, and `irq_line` is 0.
- R2: A 1 on `src_pulse[i]` for one cycle sets status bit i from the next cycle on. The bit stays set until it is cleared by a take read or an acknowledge.
- R3: A write to word address 0 loads the whole mask. A read of address 0 returns the mask. A mask bit of 1 blocks its source and a 0 passes it.
- R4: A write to address 1 sets every mask bit written as 1 and leaves the other bits unchanged.
- R5: A write to address 2 clears every mask bit written as 1 and leaves the other bits unchanged.
- R6: A read of address 3 returns the status and does not change it.
- R7: A read of address 4 returns the status. All status bits are then cleared at the same clock edge.
- R8: A write to address 5 clears each status bit written as 1. Bits written as 0 are not affected.
- R9: A source pulse that arrives in the same cycle as a take read or an acknowledge of its bit leaves that bit set.
- R10: The configuration sits at address 6, with bit 0 as enable and bit 1 as active-low. When enabled, the line goes active one cycle after (status AND NOT mask) becomes nonzero, and inactive one cycle after it becomes zero. Pending bits that are only masked never make the line active.
- R11: When bit 1 is set, the active level is 0 and the inactive level is 1. When the enable is 0, the line holds its inactive level whatever the status.
- R12: Reads of addresses 1, 2, 5 and any unmapped address return 0. Writes to addresses 3 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | NSRC (32) | Single-cycle event pulses from the sources |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_line | output | 1 | Registered host interrupt line |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any access. They also assume that bus fields and source pulses are stable around each rising edge. Under those conditions the clocked properties on status, mask and line compare each cycle only with the previous one. The stimulus changes every input on the falling edge and issues one bus access per two cycles. Source pulses are issued either alone or in the exact cycle of a take read or an acknowledge, which is the collision case of R9.

// File: rtl/hirq_pkg.sv
// Shared definitions for the host interrupt controller: register word
// addresses, configuration bit positions and default source assignment.
package hirq_pkg;
    localparam int ADDR_W = 4;

    // Word addresses of the register window.
    typedef enum logic [ADDR_W-1:0] {
        RA_MASK      = 4'd0,
        RA_MASK_SET  = 4'd1,
        RA_MASK_CLR  = 4'd2,
        RA_STAT_PEEK = 4'd3,
        RA_STAT_TAKE = 4'd4,
        RA_ACK       = 4'd5,
        RA_CFG       = 4'd6
    } reg_addr_e;

    // Configuration bit positions.
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_LOW_BIT = 1;

    // Default source bit assignment.
    localparam int SRC_RXBUF0   = 0;
    localparam int SRC_TXDATA   = 1;
    localparam int SRC_TXXFER   = 2;
    localparam int SRC_RXBUF1   = 3;
    localparam int SRC_RXXFER   = 4;
    localparam int SRC_EVT_A    = 5;
    localparam int SRC_EVT_B    = 6;
    localparam int SRC_WAKE     = 7;
    localparam int SRC_TRACE_A  = 8;
    localparam int SRC_TRACE_B  = 9;
    localparam int SRC_CMD_DONE = 10;
    localparam int SRC_INIT_DONE = 14;
endpackage

// File: rtl/hirq_status.sv
// Sticky pending-status register.
// Each bit is set by a one-cycle source pulse and cleared by the clear
// vector. A pulse and a clear on the same bit in one cycle leave the bit
// set. Assumes clr_i is already decoded from the bus.
module hirq_status #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] status_o
);
    // Latch pulses, apply clears; the set term comes last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_i) | src_i;
    end

    // R2
    pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_o & $past(src_i)) == $past(src_i)));
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));
endmodule

// File: rtl/hirq_mask.sv
// Mask register with three write paths: a whole-word load, set-by-one and
// clear-by-one. Assumes at most one write strobe is active per cycle, which
// the address decode guarantees.
module hirq_mask #(
    parameter int          NSRC     = 32,
    parameter logic [31:0] MASK_RST = 32'h0000_0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_all_i,
    input  logic            wr_set_i,
    input  logic            wr_clr_i,
    input  logic [NSRC-1:0] wd_i,
    output logic [NSRC-1:0] mask_o
);
    localparam logic [NSRC-1:0] RST_VAL = MASK_RST[NSRC-1:0];

    // Apply whichever mask write path is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_o <= RST_VAL;
        else if (wr_all_i) mask_o <= wd_i;
        else if (wr_set_i) mask_o <= mask_o | wd_i;
        else if (wr_clr_i) mask_o <= mask_o & ~wd_i;
    end

    // R1
    mask_reset_chk: assert property (@(posedge clk) !rst_n |=> (mask_o == RST_VAL));
    // R4
    set_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_set_i) |->
            ((mask_o & $past(wd_i)) == $past(wd_i)) &&
            ((mask_o & ~$past(wd_i)) == ($past(mask_o) & ~$past(wd_i))));
    // R5
    clr_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_clr_i) |->
            ((mask_o & $past(wd_i)) == '0) &&
            ((mask_o & ~$past(wd_i)) == ($past(mask_o) & ~$past(wd_i))));
endmodule

// File: rtl/hirq_line.sv
// Configuration register and registered host line generator.
// The line is active when enabled and any pending bit is unmasked. The
// active-low bit inverts the output level. Assumes status and mask come
// from registers, so the line lags them by exactly one cycle.
module hirq_line #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic [1:0]      cfg_wd_i,
    input  logic [NSRC-1:0] status_i,
    input  logic [NSRC-1:0] mask_i,
    output logic            cfg_en_o,
    output logic            cfg_low_o,
    output logic            irq_o
);
    logic pend;

    // Any pending source that the mask lets through.
    always_comb pend = |(status_i & ~mask_i);

    // Hold the enable and polarity configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en_o  <= 1'b0;
            cfg_low_o <= 1'b0;
        end else if (cfg_we_i) begin
            cfg_en_o  <= cfg_wd_i[0];
            cfg_low_o <= cfg_wd_i[1];
        end
    end

    // Register the line so that it never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= (cfg_en_o & pend) ^ cfg_low_o;
    end

    // R11
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(cfg_en_o) |-> (irq_o == $past(cfg_low_o)));
    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(status_i & ~mask_i) == '0) |-> (irq_o == $past(cfg_low_o)));
endmodule

// File: rtl/host_irq_ctrl.sv
// Host interrupt controller top: decodes the register window, builds the
// status clear vector, and muxes registered read data. Assumes a simple
// synchronous bus on which a read returns data one cycle after the request.
module host_irq_ctrl
    import hirq_pkg::*;
#(
    parameter int          NSRC     = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] MASK_RST = 32'h0000_0001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_pulse,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                irq_line
);
    logic            wr, rd;
    logic            wr_mask, wr_set, wr_clr, wr_ack, wr_cfg, rd_take;
    logic [NSRC-1:0] clr_vec, status, mask;
    logic            cfg_en, cfg_low;
    logic [DW-1:0]   rd_mux;

    // Split the bus request into one strobe per register.
    always_comb begin
        wr      = bus_sel & bus_we;
        rd      = bus_sel & ~bus_we;
        wr_mask = wr && (bus_addr == RA_MASK);
        wr_set  = wr && (bus_addr == RA_MASK_SET);
        wr_clr  = wr && (bus_addr == RA_MASK_CLR);
        wr_ack  = wr && (bus_addr == RA_ACK);
        wr_cfg  = wr && (bus_addr == RA_CFG);
        rd_take = rd && (bus_addr == RA_STAT_TAKE);
    end

    // Status clear comes from a take read (all bits) or an acknowledge (written ones).
    always_comb begin
        clr_vec = {NSRC{rd_take}};
        if (wr_ack) clr_vec = clr_vec | bus_wdata[NSRC-1:0];
    end

    hirq_status #(.NSRC(NSRC)) u_status (
        .clk(clk), .rst_n(rst_n), .src_i(src_pulse), .clr_i(clr_vec), .status_o(status)
    );

    hirq_mask #(.NSRC(NSRC), .MASK_RST(MASK_RST)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_all_i(wr_mask), .wr_set_i(wr_set),
        .wr_clr_i(wr_clr), .wd_i(bus_wdata[NSRC-1:0]), .mask_o(mask)
    );

    hirq_line #(.NSRC(NSRC)) u_line (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(wr_cfg), .cfg_wd_i(bus_wdata[1:0]),
        .status_i(status), .mask_i(mask), .cfg_en_o(cfg_en), .cfg_low_o(cfg_low),
        .irq_o(irq_line)
    );

    // Select read data; write-only and unmapped addresses read as zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            RA_MASK:      rd_mux = DW'(mask);
            RA_STAT_PEEK: rd_mux = DW'(status);
            RA_STAT_TAKE: rd_mux = DW'(status);
            RA_CFG: begin
                rd_mux[CFG_EN_BIT]  = cfg_en;
                rd_mux[CFG_LOW_BIT] = cfg_low;
            end
            default:      rd_mux = '0;
        endcase
    end

    // Register read data for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
        else         bus_rdata <= '0;
    end

    // R7
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_take) |-> (status == $past(src_pulse)));
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_ack) |->
            ((status & $past(bus_wdata[NSRC-1:0]) & ~$past(src_pulse)) == '0));
    // R9
    pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_take | wr_ack) |->
            ((status & $past(src_pulse)) == $past(src_pulse)));
endmodule

// File: tb/host_irq_ctrl_tb.sv
`timescale 1ns/1ps
module host_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_pulse = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_line;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_v = 1'b0;

    host_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_line(irq_line)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string t);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Monitor: a read is captured at a rising edge, compared at the next falling edge.
    always @(posedge clk) mon_v <= rst_n && bus_sel && !bus_we;
    always @(negedge clk) begin
        if (mon_v) begin
            if (exp_q.size() == 0) begin
                nchk++; nerr++;
                $display("FAIL scoreboard underrun actual=%h expected=none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // Driver: one bus access with an optional simultaneous source pulse.
    task automatic acc(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input logic [31:0] s, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; src_pulse = s;
        if (!we) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; src_pulse = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        acc(1'b1, a, d, '0, '0, "");
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        acc(1'b0, a, '0, '0, e, t);
    endtask

    task automatic pulse(input logic [31:0] s);
        @(negedge clk); src_pulse = s;
        @(negedge clk); src_pulse = '0;
    endtask

    task automatic chk_line(input logic e, input string t);
        @(negedge clk);
        check({31'b0, irq_line}, {31'b0, e}, t);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #(200000 * 20);
        nchk++; nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_line(1'b0, "R1 line after reset");
        rd(4'd0, 32'h0000_0001, "R1 mask reset");
        rd(4'd3, 32'h0, "R1 status reset");
        rd(4'd6, 32'h0, "R1 cfg reset");
        // R10 enable; a masked source alone keeps the line quiet
        wr(4'd6, 32'h1);
        pulse(32'h1);
        chk_line(1'b0, "R10 masked pending only");
        rd(4'd3, 32'h1, "R2 masked bit still latched");
        // R2, R10 unmasked sources
        pulse(32'h0000_4400);
        chk_line(1'b1, "R10 line active");
        rd(4'd3, 32'h0000_4401, "R6 peek first");
        rd(4'd3, 32'h0000_4401, "R6 peek unchanged");
        // R8 acknowledge
        wr(4'd5, 32'h0000_0400);
        rd(4'd3, 32'h0000_4001, "R8 ack one bit");
        // R3, R4, R5 mask paths
        wr(4'd0, 32'hFFFF_0000);
        rd(4'd0, 32'hFFFF_0000, "R3 whole mask load");
        chk_line(1'b1, "R3 unmasked line");
        wr(4'd1, 32'h0000_4001);
        rd(4'd0, 32'hFFFF_4001, "R4 mask set");
        chk_line(1'b0, "R10 line drops when all masked");
        wr(4'd2, 32'hFFFF_0000);
        rd(4'd0, 32'h0000_4001, "R5 mask clear");
        // R7 take view
        rd(4'd4, 32'h0000_4001, "R7 take returns");
        rd(4'd3, 32'h0, "R7 take cleared");
        // R9 collisions
        pulse(32'h20);
        acc(1'b0, 4'd4, '0, 32'h80, 32'h20, "R9 take with pulse returns old");
        rd(4'd3, 32'h80, "R9 pulse survives take");
        acc(1'b1, 4'd5, 32'h80, 32'h80, '0, "");
        rd(4'd3, 32'h80, "R9 pulse survives ack");
        // R11 polarity and enable
        wr(4'd6, 32'h3);
        rd(4'd6, 32'h3, "R10 cfg readback");
        chk_line(1'b0, "R11 active low asserted");
        wr(4'd5, 32'h80);
        chk_line(1'b1, "R11 active low idle");
        wr(4'd6, 32'h2);
        pulse(32'h2);
        chk_line(1'b1, "R11 disabled low idle");
        wr(4'd6, 32'h0);
        chk_line(1'b0, "R11 disabled high idle");
        // R12 write-only and read-only addresses
        rd(4'd1, 32'h0, "R12 set addr reads zero");
        rd(4'd2, 32'h0, "R12 clr addr reads zero");
        rd(4'd5, 32'h0, "R12 ack addr reads zero");
        rd(4'd15, 32'h0, "R12 unmapped reads zero");
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd3, 32'h2, "R12 status writes ignored");
        rd(4'd0, 32'h0000_4001, "R12 mask untouched");
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule